// File: doc/BRIEF.md
# Receiver Operating Mode Controller

This block is the top-level mode sequencer of a wireless receiver's digital control core. Two register bits select the operating mode: a slave-receive enable and a mode select. From those two bits the controller moves between an idle sleep state, a shared initialization state, free-running slave reception, a periodic self-polling loop, and continuous reception after a wake-up match. A hold request parks the controller in a second idle state.

Status strobes come from the receive datapath. They report that init has completed, that a wake-up check has finished and whether it matched, that an end of message was seen, and that the polling timer has expired. The controller drives a mode code, a one-clock initialize pulse for the receive part, receiver-active and polling-active flags, and a permit that tells the register file when configuration may be written.

Configuration may change only while the controller is idle. Every way out of an idle state passes through init, so a new configuration always takes effect through a fresh initialization.

Top module: `rx_mode_ctrl`

## Requirements
- R1: While reset is high and on the first clock after it, mode_code is 0 (sleep), cfg_wr_ok is 1, and rx_init_pulse, rx_active and poll_active are 0.
- R2: In sleep, with poll_mode_sel=0 and slv_rx_en=1, the next mode is 1 (init). From init, init_done moves the controller to mode 2 (slave run) with rx_active=1.
- R3: In slave run, poll_mode_sel=1 returns the controller to init (mode 1). The wake-up strobes have no effect there.
- R4: With poll_mode_sel=1, slv_rx_en is ignored. Sleep moves to init, and init_done then enters mode 3 (self polling) with poll_active=1 and rx_active=0.
- R5: In self polling, a cycle with wu_chk_done=1 and wu_found=1 moves the controller to mode 4 (run after wake-up) with rx_active=1. If wu_chk_done=1 and wu_found=0, it stays in mode 3.
- R6: In mode 4, the controller stays while eom_found and poll_timeout are both 0. It returns to mode 3 one clock after eom_found, poll_timeout, or both are high.
- R7: When poll_mode_sel=0 and slv_rx_en=0, every non-sleep mode goes to mode 0 on the next clock.
- R8: rx_init_pulse is high for exactly one clock, in the first cycle of each entry into init. It stays low for the rest of the time spent in init.
- R9: A wu_found strobe seen in any mode other than self polling does not lead to mode 4.
- R10: cfg_wr_ok is 1 exactly when mode_code is 0 (sleep) or 5 (hold).
- R11: hold_req=1 in init, slave run, self polling or run after wake-up moves the controller to mode 5 (hold). When hold_req drops, it moves to init with a fresh pulse. hold_req is ignored in sleep.
- R12: The idle request (both bits 0) takes priority over hold_req, and hold_req takes priority over mode-bit changes and datapath strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slv_rx_en | input | 1 | Register bit: enable slave reception |
| poll_mode_sel | input | 1 | Register bit: 1 selects self polling |
| hold_req | input | 1 | Request to park in the hold state |
| init_done | input | 1 | Receive-part initialization complete |
| wu_found | input | 1 | Wake-up criterion matched |
| wu_chk_done | input | 1 | Wake-up check of one poll finished |
| eom_found | input | 1 | End of message detected |
| poll_timeout | input | 1 | Polling timer expired |
| mode_code | output | 3 | Current mode: 0 sleep, 1 init, 2 slave run, 3 self polling, 4 run after wake-up, 5 hold |
| rx_init_pulse | output | 1 | One-clock initialize pulse for the receive part |
| rx_active | output | 1 | Receiver permanently active (modes 2 and 4) |
| poll_active | output | 1 | Periodic polling active (mode 3) |
| cfg_wr_ok | output | 1 | Configuration writes allowed |

## Verification
The assertions assume that every input is synchronous to clk and settled before each rising edge. They also assume that wu_found means something only when it arrives with wu_chk_done, and that no other relation holds between the strobes. The bench changes inputs only on falling edges. Its random phase changes the two mode bits and hold_req rarely, so that every path has time to develop, and it fires the datapath strobes freely in every mode. Strobes that arrive in the wrong mode, and simultaneous end-of-message and timeout, are therefore part of the legal stimulus.

// File: rtl/rx_mode_pkg.sv
package rx_mode_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_SLEEP = 3'd0,
    M_INIT  = 3'd1,
    M_SLAVE = 3'd2,
    M_POLL  = 3'd3,
    M_RUNWU = 3'd4,
    M_HOLD  = 3'd5
  } mode_e;

  // Decoded, prioritised requests from the register bits.
  typedef struct packed {
    logic go_idle;     // both mode bits low
    logic go_hold;     // hold request, not overridden by idle
    logic want_poll;   // polling path selected
    logic want_slave;  // slave path selected
  } req_t;

  typedef struct packed {
    logic wu_found;
    logic wu_chk_done;
    logic eom_found;
    logic poll_timeout;
    logic init_done;
  } strobe_t;

endpackage

// File: rtl/rx_mode_req_decode.sv
module rx_mode_req_decode
  import rx_mode_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic slv_rx_en,
  input  logic poll_mode_sel,
  input  logic hold_req,
  output req_t req
);

  always_comb begin
    req.go_idle    = !poll_mode_sel && !slv_rx_en;
    req.go_hold    = hold_req && !req.go_idle;
    req.want_poll  = poll_mode_sel;
    req.want_slave = !poll_mode_sel && slv_rx_en;
  end

  // R12: exactly one of idle / poll / slave is requested at a time
  a_r12_req_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({req.go_idle, req.want_poll, req.want_slave}) == 1);

  // R12: hold never survives an idle request
  a_r12_idle_over_hold: assert property (@(posedge clk) disable iff (rst)
    (!poll_mode_sel && !slv_rx_en) |-> !req.go_hold);

endmodule

// File: rtl/rx_mode_fsm.sv
module rx_mode_fsm
  import rx_mode_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  req_t    req,
  input  strobe_t stb,
  output mode_e   state,
  output mode_e   state_nxt
);

  logic wu_match;
  logic run_end;

  assign wu_match = stb.wu_chk_done && stb.wu_found;
  assign run_end  = stb.eom_found || stb.poll_timeout;

  always_comb begin
    state_nxt = state;
    unique case (state)
      M_SLEEP: begin
        if (!req.go_idle) state_nxt = M_INIT;
      end
      M_INIT: begin
        if (req.go_idle)         state_nxt = M_SLEEP;
        else if (req.go_hold)    state_nxt = M_HOLD;
        else if (stb.init_done)  state_nxt = req.want_poll ? M_POLL : M_SLAVE;
      end
      M_SLAVE: begin
        if (req.go_idle)         state_nxt = M_SLEEP;
        else if (req.go_hold)    state_nxt = M_HOLD;
        else if (req.want_poll)  state_nxt = M_INIT;
      end
      M_POLL: begin
        if (req.go_idle)         state_nxt = M_SLEEP;
        else if (req.go_hold)    state_nxt = M_HOLD;
        else if (req.want_slave) state_nxt = M_INIT;
        else if (wu_match)       state_nxt = M_RUNWU;
      end
      M_RUNWU: begin
        if (req.go_idle)         state_nxt = M_SLEEP;
        else if (req.go_hold)    state_nxt = M_HOLD;
        else if (req.want_slave) state_nxt = M_INIT;
        else if (run_end)        state_nxt = M_POLL;
      end
      M_HOLD: begin
        if (req.go_idle)         state_nxt = M_SLEEP;
        else if (!req.go_hold)   state_nxt = M_INIT;
      end
      default: state_nxt = M_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= M_SLEEP;
    else     state <= state_nxt;
  end

  // R7: idle request empties any active state within one clock
  a_r7_idle_to_sleep: assert property (@(posedge clk) disable iff (rst)
    (state != M_SLEEP && req.go_idle) |=> state == M_SLEEP);

  // R5: matched wake-up check leaves polling for continuous reception
  a_r5_poll_to_runwu: assert property (@(posedge clk) disable iff (rst)
    (state == M_POLL && !req.go_idle && !req.go_hold && req.want_poll && wu_match)
    |=> state == M_RUNWU);

  // R6: end of message or timeout (either or both) returns to polling
  a_r6_runwu_return: assert property (@(posedge clk) disable iff (rst)
    (state == M_RUNWU && req.want_poll && !req.go_hold && run_end)
    |=> state == M_POLL);

  // R9: run-after-wake-up is entered only from polling
  a_r9_runwu_only_from_poll: assert property (@(posedge clk) disable iff (rst)
    (state != M_POLL && state != M_RUNWU) |=> state != M_RUNWU);

  // R11: hold is reached only from an active state
  a_r11_hold_entry: assert property (@(posedge clk) disable iff (rst)
    (state == M_SLEEP) |=> state != M_HOLD);

endmodule

// File: rtl/rx_mode_outreg.sv
module rx_mode_outreg
  import rx_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  mode_e             state,
  input  mode_e             state_nxt,
  output logic [MODE_W-1:0] mode_code,
  output logic              rx_init_pulse,
  output logic              rx_active,
  output logic              poll_active,
  output logic              cfg_wr_ok
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_code     <= M_SLEEP;
      rx_init_pulse <= 1'b0;
      rx_active     <= 1'b0;
      poll_active   <= 1'b0;
      cfg_wr_ok     <= 1'b1;
    end else begin
      mode_code     <= state_nxt;
      rx_init_pulse <= (state_nxt == M_INIT) && (state != M_INIT);
      rx_active     <= (state_nxt == M_SLAVE) || (state_nxt == M_RUNWU);
      poll_active   <= (state_nxt == M_POLL);
      cfg_wr_ok     <= (state_nxt == M_SLEEP) || (state_nxt == M_HOLD);
    end
  end

  // R8: pulse never lasts two clocks
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (rst)
    rx_init_pulse |=> !rx_init_pulse);

  // R8: a pulse-less init cycle must be a continuation of init
  a_r8_pulse_on_entry: assert property (@(posedge clk) disable iff (rst)
    (mode_code == M_INIT && !rx_init_pulse) |-> $past(mode_code) == M_INIT);

  // R10: permit only in idle modes
  a_r10_cfg_idle_only: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_ok |-> (mode_code == M_SLEEP || mode_code == M_HOLD));

  // R4: polling and continuous reception never overlap
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_active, poll_active, cfg_wr_ok}));

endmodule

// File: rtl/rx_mode_ctrl.sv
module rx_mode_ctrl
  import rx_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              slv_rx_en,
  input  logic              poll_mode_sel,
  input  logic              hold_req,
  input  logic              init_done,
  input  logic              wu_found,
  input  logic              wu_chk_done,
  input  logic              eom_found,
  input  logic              poll_timeout,
  output logic [MODE_W-1:0] mode_code,
  output logic              rx_init_pulse,
  output logic              rx_active,
  output logic              poll_active,
  output logic              cfg_wr_ok
);

  req_t    req;
  strobe_t stb;
  mode_e   state;
  mode_e   state_nxt;

  assign stb.wu_found     = wu_found;
  assign stb.wu_chk_done  = wu_chk_done;
  assign stb.eom_found    = eom_found;
  assign stb.poll_timeout = poll_timeout;
  assign stb.init_done    = init_done;

  rx_mode_req_decode u_decode (
    .clk           (clk),
    .rst           (rst),
    .slv_rx_en     (slv_rx_en),
    .poll_mode_sel (poll_mode_sel),
    .hold_req      (hold_req),
    .req           (req)
  );

  rx_mode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .stb       (stb),
    .state     (state),
    .state_nxt (state_nxt)
  );

  rx_mode_outreg u_out (
    .clk           (clk),
    .rst           (rst),
    .state         (state),
    .state_nxt     (state_nxt),
    .mode_code     (mode_code),
    .rx_init_pulse (rx_init_pulse),
    .rx_active     (rx_active),
    .poll_active   (poll_active),
    .cfg_wr_ok     (cfg_wr_ok)
  );

  // R2: slave path always enters through init
  a_r2_slave_via_init: assert property (@(posedge clk) disable iff (rst)
    (mode_code != M_SLAVE && mode_code != M_INIT) |=> mode_code != M_SLAVE);

  // R11: leaving hold for an active mode goes through init
  a_r11_hold_exit: assert property (@(posedge clk) disable iff (rst)
    (mode_code == M_HOLD) |=> (mode_code == M_HOLD || mode_code == M_INIT
                               || mode_code == M_SLEEP));

endmodule

// File: tb/test_rx_mode_ctrl.sv
module test_rx_mode_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 0, sel = 0, hold = 0, idone = 0, fnd = 0, chk = 0, eom = 0, tmo = 0;
  logic [2:0] mode_code;
  logic       rx_init_pulse, rx_active, poll_active, cfg_wr_ok;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [2:0] ref_st;

  always #2 clk = ~clk;   // 250 MHz

  rx_mode_ctrl i_rx_mode_ctrl (
    .clk(clk), .rst(rst), .slv_rx_en(en), .poll_mode_sel(sel), .hold_req(hold),
    .init_done(idone), .wu_found(fnd), .wu_chk_done(chk), .eom_found(eom),
    .poll_timeout(tmo), .mode_code(mode_code), .rx_init_pulse(rx_init_pulse),
    .rx_active(rx_active), .poll_active(poll_active), .cfg_wr_ok(cfg_wr_ok)
  );

  // Expected next mode, written from the requirements.
  function automatic logic [2:0] ref_next(input logic [2:0] s);
    logic idle, hl;
    idle = !sel && !en;
    hl   = hold && !idle;
    if (s == 3'd0) return idle ? 3'd0 : 3'd1;
    if (idle) return 3'd0;
    if (s == 3'd5) return hl ? 3'd5 : 3'd1;
    if (hl) return 3'd5;
    case (s)
      3'd1: return idone ? (sel ? 3'd3 : 3'd2) : 3'd1;
      3'd2: return sel ? 3'd1 : 3'd2;
      3'd3: return !sel ? 3'd1 : ((chk && fnd) ? 3'd4 : 3'd3);
      3'd4: return !sel ? 3'd1 : ((eom || tmo) ? 3'd3 : 3'd4);
      default: return 3'd0;
    endcase
  endfunction

  function automatic string ref_tag(input logic [2:0] s);
    if (!sel && !en && hold && s != 3'd0) return "R12";
    if (s != 3'd0 && !sel && !en) return "R7";
    if (s == 3'd5 || (hold && s != 3'd0)) return "R11";
    case (s)
      3'd0: return sel ? "R4" : "R2";
      3'd1: return sel ? "R4" : "R2";
      3'd2: return fnd ? "R9" : "R3";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic chk1(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // Drive inputs (just after a falling edge), then check one clock later.
  task automatic step(input logic s_sel, input logic s_en, input logic s_hold,
                      input logic s_idone, input logic s_chk, input logic s_fnd,
                      input logic s_eom, input logic s_tmo);
    logic [2:0] nx;
    string tg;
    sel = s_sel; en = s_en; hold = s_hold; idone = s_idone;
    chk = s_chk; fnd = s_fnd; eom = s_eom; tmo = s_tmo;
    nx = ref_next(ref_st);
    tg = ref_tag(ref_st);
    @(negedge clk);
    cyc++;
    chk1(tg, "mode", int'(mode_code), int'(nx));
    chk1("R8", "init_pulse", int'(rx_init_pulse), int'(nx == 3'd1 && ref_st != 3'd1));
    chk1("R10", "cfg_wr_ok", int'(cfg_wr_ok), int'(nx == 3'd0 || nx == 3'd5));
    chk1(tg, "rx_active", int'(rx_active), int'(nx == 3'd2 || nx == 3'd4));
    chk1(tg, "poll_active", int'(poll_active), int'(nx == 3'd3));
    ref_st = nx;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic r_sel, r_en, r_hold;
    void'($urandom(32'd20240611));
    ref_st = 3'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk1("R1", "mode", int'(mode_code), 0);
    chk1("R1", "cfg_wr_ok", int'(cfg_wr_ok), 1);
    chk1("R1", "flags", int'({rx_init_pulse, rx_active, poll_active}), 0);
    rst = 1'b0;
    step(0,0,0,0,0,0,0,0);                 // R1 stays in sleep
    step(0,0,1,0,0,0,0,0);                 // R11 hold ignored in sleep
    // R2 slave path
    step(0,1,0,0,0,0,0,0);
    step(0,1,0,0,0,0,0,0);                 // R8 pulse only once
    step(0,1,0,1,0,0,0,0);
    step(0,1,0,0,1,1,0,0);                 // R9 wake-up ignored in slave
    step(0,1,0,0,0,0,0,0);
    step(1,1,0,0,0,0,0,0);                 // R3 to init
    step(1,0,0,1,0,0,0,0);                 // R4 poll
    step(1,0,0,0,1,0,0,0);                 // R5 no match stays
    step(1,0,0,0,0,1,0,0);                 // R5 found without check done
    step(1,0,0,0,1,1,0,0);                 // R5 match
    step(1,0,0,0,0,0,0,0);                 // R6 stays
    step(1,0,0,0,0,0,1,1);                 // R6 both at once
    step(1,0,0,0,1,1,0,0);
    step(1,0,0,0,0,0,0,1);                 // R6 timeout
    step(1,0,1,0,0,0,0,0);                 // R11 hold
    step(1,0,1,0,0,0,0,0);
    step(1,0,0,0,0,0,0,0);                 // R11 exit via init
    step(1,0,0,1,0,0,0,0);
    step(0,0,1,0,0,0,0,0);                 // R12 idle over hold, R7
    step(0,1,0,0,0,0,0,0);
    step(0,1,0,1,0,0,0,0);
    step(0,0,0,0,0,0,0,0);                 // R7 slave to sleep
    // Random phase
    r_sel = 0; r_en = 0; r_hold = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 19) == 0) r_sel  = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 19) == 0) r_en   = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 39) == 0) r_hold = ~r_hold;
      step(r_sel, r_en, r_hold,
           1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 2) == 0),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 5) == 0),
           1'($urandom_range(0, 7) == 0));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule